// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block holds the configuration header of a 32-bit PCI target that sits behind a fixed protocol core. The core delivers configuration writes as a one-cycle strobe with a dword index, 32-bit data and active-low byte enables. Reads return 32 bits for the dword index on the address input, with no added latency. Identity fields are constants set by parameters. The command enables, the latency timer and up to two base address registers are writable.

The block also collects error events. The core raises one-cycle pulses when it detects a parity error, when it signals a system error, and when its master side sees a data parity error. Each pulse sets a sticky bit in the status half of dword 1. Software clears a sticky bit by writing a one to it.

The block drives its state straight to the logic around it. The I/O-space and memory-space enables go to the address decoder. The parity-response and system-error enables go to the protocol core. The latency timer goes to the master logic, and the BAR contents go to the decoder.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, dwords 1 and 3 read 0, every BAR reads only its type bits, and all enable outputs and the latency timer output are 0.
- R2: Dword 0 reads {device_id, vendor_id} and dword 2 reads {class_code[23:0], revision_id[7:0]}. Writes to either dword have no effect.
- R3: Command bits 0 (I/O enable), 1 (memory enable), 6 (parity response) and 8 (SERR enable) are writable in dword 1. All other command bits read 0. The matching outputs change on the clock edge after the write.
- R4: A parity-detected pulse sets status bit 15 (dword bit 31). A system-error pulse sets bit 14 (dword bit 30). A master data-parity pulse sets bit 8 (dword bit 24). Each bit is set on the clock edge after its pulse.
- R5: Status bits 15, 14 and 8 are write-one-to-clear. Writing 0 leaves them unchanged. If an event pulse and a clearing write arrive in the same cycle, the bit stays set.
- R6: A write updates only the byte lanes whose active-low enable is 0. Lane n covers bits 8n+7:8n. The latency timer sits in lane 1 of dword 3 (bits 15:8).
- R7: BAR0 (dword 4) is a 32-bit memory BAR. Bits 3:0 read 0000 and it decodes 2^BAR0_SIZE_LOG2 bytes. BAR1 (dword 5) is an I/O BAR. Bits 1:0 read 01 and it decodes 2^BAR1_SIZE_LOG2 bytes. Address bits below the size read 0, so writing all ones reads back as the size mask.
- R8: bar_o carries the readable value of BAR k in bits 32k+31:32k.
- R9: Dword indices with no register read 0, and writes to them change nothing.
- R10: cfg_rdata_o is a function of cfg_addr_i and the current register state, valid in the same cycle the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Dword index for reads and writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_be_ni | input | 4 | Active-low byte enables |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| perr_det_i | input | 1 | Parity error detected pulse |
| serr_sig_i | input | 1 | System error signalled pulse |
| mst_perr_i | input | 1 | Master data parity error pulse |
| io_en_o | output | 1 | Command bit 0 |
| mem_en_o | output | 1 | Command bit 1 |
| perr_resp_o | output | 1 | Command bit 6 |
| serr_en_o | output | 1 | Command bit 8 |
| lat_timer_o | output | 8 | Latency timer value |
| bar_o | output | NUM_BARS*32 | BAR contents, BAR0 in the low word |

## Verification
The assertions check on every cycle that each error pulse sets its status bit. They also check that a set bit survives any cycle without a matching clearing write, and that a clearing write with no event clears the bit. They further check that the command enables and the latency timer hold still when no write reaches them. The bench's scenarios are what show the rest: identity fields ignoring writes, partial byte-lane updates, BAR size masks and type bits, the tie between an event and a clear in the same cycle, and zero reads from empty offsets. A behavioural model compared every cycle covers the read mux across all touched indices.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned DW_ID      = 0;
  localparam int unsigned DW_CMDSTAT = 1;
  localparam int unsigned DW_CLASS   = 2;
  localparam int unsigned DW_MISC    = 3;
  localparam int unsigned DW_BAR0    = 4;

  localparam logic [15:0] CMD_RW_MASK   = 16'h0143;
  localparam logic [15:0] STAT_W1C_MASK = 16'hC100;

  function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{~be_n[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
  import cfg_space_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_ni,
  input  logic        perr_det_i,
  input  logic        serr_sig_i,
  input  logic        mst_perr_i,
  output logic [15:0] cmd_o,
  output logic [15:0] stat_o
);
  logic [31:0] lm;
  logic [15:0] cmd_q, stat_q, cmd_m, clr, set;

  assign lm    = lane_mask(be_ni);
  assign cmd_m = CMD_RW_MASK & lm[15:0];
  assign clr   = wr_i ? (wdata_i[31:16] & lm[31:16] & STAT_W1C_MASK) : 16'h0;
  assign set   = {perr_det_i, serr_sig_i, 5'b0, mst_perr_i, 8'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_i) cmd_q <= (cmd_q & ~cmd_m) | (wdata_i[15:0] & cmd_m);
      // event set wins over same-cycle clear
      stat_q <= (stat_q & ~clr) | set;
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_space_pkg::*;
#(
  parameter bit          IS_IO     = 1'b0,
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_ni,
  output logic [31:0] bar_o
);
  localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : 32'h0;

  logic [31:0] lm, base_q;
  assign lm = lane_mask(be_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (wr_i) base_q <= ((base_q & ~lm) | (wdata_i & lm)) & ADDR_MASK;
  end

  assign bar_o = base_q | TYPE_BITS;
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID      = 16'hABCD,
  parameter logic [15:0] DEVICE_ID      = 16'h5A17,
  parameter logic [7:0]  REVISION_ID    = 8'h03,
  parameter logic [23:0] CLASS_CODE     = 24'h118000,
  parameter int unsigned NUM_BARS       = 2,
  parameter logic [1:0]  BAR_IS_IO      = 2'b10,
  parameter int unsigned BAR0_SIZE_LOG2 = 12,
  parameter int unsigned BAR1_SIZE_LOG2 = 8,
  parameter int unsigned ADDR_W         = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_wr_i,
  input  logic [ADDR_W-1:0]      cfg_addr_i,
  input  logic [31:0]            cfg_wdata_i,
  input  logic [3:0]             cfg_be_ni,
  output logic [31:0]            cfg_rdata_o,
  input  logic                   perr_det_i,
  input  logic                   serr_sig_i,
  input  logic                   mst_perr_i,
  output logic                   io_en_o,
  output logic                   mem_en_o,
  output logic                   perr_resp_o,
  output logic                   serr_en_o,
  output logic [7:0]             lat_timer_o,
  output logic [NUM_BARS*32-1:0] bar_o
);
  logic [15:0] cmd_w, stat_w;
  logic [7:0]  lat_q;
  logic        cs_wr, misc_wr;

  assign cs_wr   = cfg_wr_i && (cfg_addr_i == ADDR_W'(DW_CMDSTAT));
  assign misc_wr = cfg_wr_i && (cfg_addr_i == ADDR_W'(DW_MISC)) && !cfg_be_ni[1];

  cfg_cmd_stat u_cmd_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cs_wr),
    .wdata_i    (cfg_wdata_i),
    .be_ni      (cfg_be_ni),
    .perr_det_i (perr_det_i),
    .serr_sig_i (serr_sig_i),
    .mst_perr_i (mst_perr_i),
    .cmd_o      (cmd_w),
    .stat_o     (stat_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (misc_wr) lat_q <= cfg_wdata_i[15:8];
  end

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    cfg_bar #(
      .IS_IO     (BAR_IS_IO[g]),
      .SIZE_LOG2 ((g == 0) ? BAR0_SIZE_LOG2 : BAR1_SIZE_LOG2)
    ) u_bar (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_wr_i && (cfg_addr_i == ADDR_W'(DW_BAR0 + g))),
      .wdata_i (cfg_wdata_i),
      .be_ni   (cfg_be_ni),
      .bar_o   (bar_o[g*32 +: 32])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      ADDR_W'(DW_ID):      cfg_rdata_o = {DEVICE_ID, VENDOR_ID};
      ADDR_W'(DW_CMDSTAT): cfg_rdata_o = {stat_w, cmd_w};
      ADDR_W'(DW_CLASS):   cfg_rdata_o = {CLASS_CODE, REVISION_ID};
      ADDR_W'(DW_MISC):    cfg_rdata_o = {16'h0, lat_q, 8'h0};
      default: begin
        for (int k = 0; k < NUM_BARS; k++)
          if (cfg_addr_i == ADDR_W'(DW_BAR0 + k)) cfg_rdata_o = bar_o[k*32 +: 32];
      end
    endcase
  end

  assign io_en_o     = cmd_w[0];
  assign mem_en_o    = cmd_w[1];
  assign perr_resp_o = cmd_w[6];
  assign serr_en_o   = cmd_w[8];
  assign lat_timer_o = lat_q;
endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [31:0]       cfg_wdata_i,
  input logic [3:0]        cfg_be_ni,
  input logic              perr_det_i,
  input logic              serr_sig_i,
  input logic              mst_perr_i,
  input logic              io_en_o,
  input logic              mem_en_o,
  input logic              perr_resp_o,
  input logic              serr_en_o,
  input logic [7:0]        lat_timer_o,
  input logic [15:0]       stat_i
);
  logic cs_hit, clr15;
  assign cs_hit = cfg_wr_i && (cfg_addr_i == ADDR_W'(1));
  assign clr15  = cs_hit && !cfg_be_ni[3] && cfg_wdata_i[31];

  a_r4_perr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_det_i |=> stat_i[15]);
  a_r4_serr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_sig_i |=> stat_i[14]);
  a_r4_mst_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_perr_i |=> stat_i[8]);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[15] && !clr15) |=> stat_i[15]);
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr15 && !perr_det_i) |=> !stat_i[15]);
  a_r3_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_hit |=> $stable({io_en_o, mem_en_o, perr_resp_o, serr_en_o}));
  a_r6_lat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wr_i && cfg_addr_i == ADDR_W'(3) && !cfg_be_ni[1]) |=> $stable(lat_timer_o));
endmodule

bind cfg_space_regs cfg_space_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_be_ni   (cfg_be_ni),
  .perr_det_i  (perr_det_i),
  .serr_sig_i  (serr_sig_i),
  .mst_perr_i  (mst_perr_i),
  .io_en_o     (io_en_o),
  .mem_en_o    (mem_en_o),
  .perr_resp_o (perr_resp_o),
  .serr_en_o   (serr_en_o),
  .lat_timer_o (lat_timer_o),
  .stat_i      (stat_w)
);

// File: tb/cfg_space_regs_test.sv
module cfg_space_regs_test;
  localparam logic [15:0] VEN = 16'hABCD;
  localparam logic [15:0] DEV = 16'h5A17;
  localparam logic [7:0]  REV = 8'h03;
  localparam logic [23:0] CLS = 24'h118000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [3:0]  cfg_be_ni = 4'hF;
  logic        perr_det_i = 1'b0, serr_sig_i = 1'b0, mst_perr_i = 1'b0;
  logic [31:0] cfg_rdata_o;
  logic        io_en_o, mem_en_o, perr_resp_o, serr_en_o;
  logic [7:0]  lat_timer_o;
  logic [63:0] bar_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cfg_space_regs #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION_ID(REV), .CLASS_CODE(CLS),
    .NUM_BARS(2), .BAR_IS_IO(2'b10), .BAR0_SIZE_LOG2(12), .BAR1_SIZE_LOG2(8), .ADDR_W(6)
  ) uut (.*);

  // behavioural reference model
  logic [15:0] m_cmd, m_stat;
  logic [7:0]  m_lat;
  logic [31:0] m_bar [2];
  localparam logic [31:0] BMASK0 = 32'hFFFF_F000;
  localparam logic [31:0] BMASK1 = 32'hFFFF_FF00;

  function automatic logic [31:0] lanes(input logic [3:0] be_n);
    return {{8{~be_n[3]}}, {8{~be_n[2]}}, {8{~be_n[1]}}, {8{~be_n[0]}}};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmd = 0; m_stat = 0; m_lat = 0; m_bar[0] = 0; m_bar[1] = 0;
    end else begin
      logic [31:0] lm;
      logic [15:0] clr;
      lm = lanes(cfg_be_ni);
      clr = 0;
      if (cfg_wr_i) begin
        if (cfg_addr_i == 1) begin
          for (int b = 0; b < 16; b++)
            if ((b == 0 || b == 1 || b == 6 || b == 8) && lm[b]) m_cmd[b] = cfg_wdata_i[b];
          for (int b = 0; b < 16; b++)
            if ((b == 15 || b == 14 || b == 8) && lm[16+b] && cfg_wdata_i[16+b]) clr[b] = 1;
        end
        if (cfg_addr_i == 3 && !cfg_be_ni[1]) m_lat = cfg_wdata_i[15:8];
        if (cfg_addr_i == 4) m_bar[0] = ((m_bar[0] & ~lm) | (cfg_wdata_i & lm)) & BMASK0;
        if (cfg_addr_i == 5) m_bar[1] = ((m_bar[1] & ~lm) | (cfg_wdata_i & lm)) & BMASK1;
      end
      m_stat = m_stat & ~clr;
      if (perr_det_i) m_stat[15] = 1;
      if (serr_sig_i) m_stat[14] = 1;
      if (mst_perr_i) m_stat[8] = 1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      0: return {DEV, VEN};
      1: return {m_stat, m_cmd};
      2: return {CLS, REV};
      3: return {16'h0, m_lat, 8'h0};
      4: return m_bar[0];
      5: return m_bar[1] | 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      chk("R10 rdata", cfg_rdata_o, exp_rd(cfg_addr_i));
      chk("R3 cmd outs", {io_en_o, mem_en_o, perr_resp_o, serr_en_o},
          {m_cmd[0], m_cmd[1], m_cmd[6], m_cmd[8]});
      chk("R6 lat", lat_timer_o, m_lat);
      chk("R8 bar_o", bar_o, {m_bar[1] | 32'h1, m_bar[0]});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be_n,
                    input logic [2:0] ev = 3'b000);
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_addr_i = a; cfg_wdata_i = d; cfg_be_ni = be_n;
    {perr_det_i, serr_sig_i, mst_perr_i} = ev;
    @(negedge clk_i);
    cfg_wr_i = 0; cfg_be_ni = 4'hF;
    {perr_det_i, serr_sig_i, mst_perr_i} = 3'b000;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk_i);
    {perr_det_i, serr_sig_i, mst_perr_i} = ev;
    @(negedge clk_i);
    {perr_det_i, serr_sig_i, mst_perr_i} = 3'b000;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd("R1 cmdstat", 1, 32'h0);
    rd("R1 misc", 3, 32'h0);
    rd("R1 bar0", 4, 32'h0);
    rd("R1 bar1", 5, 32'h1);
    chk("R1 outs", {io_en_o, mem_en_o, perr_resp_o, serr_en_o, lat_timer_o}, 12'h0);
    // R2 identity
    rd("R2 id", 0, {DEV, VEN});
    wr(0, 32'hFFFF_FFFF, 4'h0);
    rd("R2 id after write", 0, {DEV, VEN});
    wr(2, 32'h0, 4'h0);
    rd("R2 class after write", 2, {CLS, REV});
    // R3 command bits
    wr(1, 32'h0000_FFFF, 4'h0);
    rd("R3 cmd", 1, 32'h0000_0143);
    chk("R3 enables", {io_en_o, mem_en_o, perr_resp_o, serr_en_o}, 4'hF);
    // R6 lanes: only lane 1 enabled clears bit 8
    wr(1, 32'h0, 4'b1101);
    rd("R6 cmd lane1", 1, 32'h0000_0043);
    chk("R6 serr_en", {serr_en_o, io_en_o}, 2'b01);
    wr(3, 32'hFFFF_FFFF, 4'b1101);
    rd("R6 lat", 3, 32'h0000_FF00);
    wr(3, 32'h0000_2200, 4'b1110);
    chk("R6 lat lane0 only", lat_timer_o, 8'hFF);
    // R4 event pulses
    pulse(3'b111);
    rd("R4 status", 1, 32'hC100_0043);
    // R5 write-one-to-clear
    wr(1, 32'h8000_0043, 4'b0111);
    rd("R5 clear 15", 1, 32'h4100_0043);
    wr(1, 32'h0000_0043, 4'b0000);
    rd("R5 write zero keeps", 1, 32'h4100_0043);
    wr(1, 32'h4000_0043, 4'b0111, 3'b010);
    rd("R5 event wins", 1, 32'h4100_0043);
    wr(1, 32'h4100_0043, 4'b0111);
    rd("R5 clear 14 and 8", 1, 32'h0000_0043);
    // R7 BARs
    wr(4, 32'hFFFF_FFFF, 4'h0);
    rd("R7 bar0 mask", 4, 32'hFFFF_F000);
    wr(5, 32'hFFFF_FFFF, 4'h0);
    rd("R7 bar1 mask", 5, 32'hFFFF_FF01);
    wr(4, 32'h1234_5678, 4'h0);
    rd("R7 bar0 value", 4, 32'h1234_5000);
    chk("R8 bar_o", bar_o, {32'hFFFF_FF01, 32'h1234_5000});
    // R9 unimplemented
    wr(9, 32'hFFFF_FFFF, 4'h0);
    rd("R9 dword 9", 9, 32'h0);
    rd("R9 dword 6", 6, 32'h0);
    rd("R9 dword 63", 63, 32'h0);
    rd("R9 cmd untouched", 1, 32'h0000_0043);
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule